// File: doc/BRIEF.md
# Video Stream Handshake and Framing Monitor

A passive observer for one valid/ready video stream link that carries pixels on a data bus, start-of-frame on the user sideband bit and end-of-line on the last bit. It samples the link on every rising clock edge and never drives anything back onto it. When the sender breaks the handshake, or when the framing markers are out of place, it raises an error flag. Flags stay set until a clear pulse arrives. A mask picks which flags feed a single combined error output.

A beat is transferred on an edge where valid and ready are both high. The sender must hold valid, data and the sideband bits steady from the moment it raises valid until the beat transfers. Ready is entirely the receiver's choice, so no pattern on ready is ever flagged. The user bit is checked only at transfer time. A sender may therefore raise start-of-frame early while no beat is moving.

Two optional parts are built in. A line-width check, included by a parameter and enabled at run time, counts beats per line against a programmable width. Two saturating counters report the frame-start beats and line-end beats seen since reset.

Top module: `vsc_mon`

## Requirements
- R1: If valid was high and ready low on the previous edge, and valid is still high but data, user or last differs from its previous value, error bit 0 (hold) is set.
- R2: If valid was high and ready low on the previous edge and valid is now low, error bit 1 (retract) is set.
- R3: Legal traffic sets no flag. This covers ready high with valid low, ready arriving before, with or after valid, back-to-back transfers, and valid falling after a transfer.
- R4: A transferred beat with user high that directly follows a transferred beat with user high sets error bit 2 (repeated frame start).
- R5: User high on cycles with no transfer is ignored. Only its value on a transferred beat counts.
- R6: A transferred beat with last high that directly follows a transferred beat with last high sets error bit 3 (repeated line end). This means a one-pixel line is reported.
- R7: After reset, every transferred beat with user low that comes before the first transferred beat with user high sets error bit 4 (data before frame).
- R8: Flags are updated at the edge that samples the violation and stay set. When clear is high on an edge, all flags become zero on that edge, even if a violation is seen on the same edge.
- R9: The combined error output is high exactly when a flag is set whose mask bit is 0. Masking does not stop the flag from being recorded.
- R10: With the width check enabled and expected width W, a transferred beat with last high whose position in the line is below W sets error bit 5 (short line). A beat with user high counts as position 1, and the position restarts after each beat with last high.
- R11: With the width check enabled, a transferred beat with last low at position W or beyond sets error bit 6 (long line).
- R12: The two counters count transferred beats with user high and transferred beats with last high since reset. Each stops at its maximum value.
- R13: After reset, all flags, the combined output and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | DW | Observed pixel data |
| s_tvalid | input | 1 | Observed valid |
| s_tready | input | 1 | Observed ready |
| s_tuser | input | 1 | Observed start-of-frame marker |
| s_tlast | input | 1 | Observed end-of-line marker |
| err_mask | input | 7 | 1 removes that flag from err_any |
| err_clr | input | 1 | Clears all flags on the edge it is high |
| width_chk_en | input | 1 | Enables the line-width checks |
| exp_width | input | WW | Expected beats per line |
| err_flags | output | 7 | Sticky error flags, bit positions as in the requirements |
| err_any | output | 1 | OR of unmasked flags |
| sof_count | output | CW | Saturating count of frame-start beats |
| eol_count | output | CW | Saturating count of line-end beats |

## Verification
The hardest situation to reach is a violation that lands on the same edge as a clear. The stimulus stalls a beat with ready low and changes its data in the very cycle where clear is pulsed. The bench then confirms that the flags read zero, and that a later stable transfer of the same beat stays clean. The width checks need the line position to restart both on a frame start and after a line end. Directed lines of the correct length, a short length and an overlong length are sent back to back so that the position carries across them.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
   localparam int ERR_N       = 7;
   localparam int ERR_HOLD    = 0;
   localparam int ERR_RETRACT = 1;
   localparam int ERR_SOF_REP = 2;
   localparam int ERR_EOL_REP = 3;
   localparam int ERR_PREFRM  = 4;
   localparam int ERR_SHORT   = 5;
   localparam int ERR_LONG    = 6;
   typedef logic [ERR_N-1:0] err_vec_t;
endpackage

// File: rtl/vsc_hold_mon.sv
module vsc_hold_mon #(
   parameter int PW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid,
   input  logic          ready,
   input  logic [PW-1:0] payload,
   output logic          hold_hit,
   output logic          retract_hit,
   output logic          beat
);
   logic          pend_q;
   logic [PW-1:0] prev_q;

   initial assert (PW >= 3) else $error("vsc_hold_mon: PW too small");

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         prev_q <= '0;
      end else begin
         pend_q <= valid & ~ready;
         prev_q <= payload;
      end
   end

   always_comb begin
      beat        = valid & ready;
      hold_hit    = pend_q & valid & (payload != prev_q);
      retract_hit = pend_q & ~valid;
   end
endmodule

// File: rtl/vsc_frame_mon.sv
module vsc_frame_mon #(
   parameter int WW        = 12,
   parameter bit WIDTH_CHK = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          beat,
   input  logic          sof,
   input  logic          eol,
   input  logic          chk_en,
   input  logic [WW-1:0] exp_width,
   output logic          sof_rep,
   output logic          eol_rep,
   output logic          prefrm,
   output logic          short_ln,
   output logic          long_ln
);
   localparam int PSW = WW + 1;

   logic prev_sof_q, prev_eol_q, seen_sof_q;

   initial assert (WW >= 1) else $error("vsc_frame_mon: WW must be positive");

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_sof_q <= 1'b0;
         prev_eol_q <= 1'b0;
         seen_sof_q <= 1'b0;
      end else if (beat) begin
         prev_sof_q <= sof;
         prev_eol_q <= eol;
         if (sof) seen_sof_q <= 1'b1;
      end
   end

   always_comb begin
      sof_rep = beat & sof & prev_sof_q;
      eol_rep = beat & eol & prev_eol_q;
      prefrm  = beat & ~sof & ~seen_sof_q;
   end

   generate
      if (WIDTH_CHK) begin : g_width
         logic [PSW-1:0] pos_q;
         logic [PSW-1:0] idx;
         logic [PSW-1:0] expw;
         always_comb begin
            expw = {1'b0, exp_width};
            if (sof)                idx = PSW'(1);
            else if (&pos_q)        idx = pos_q;
            else                    idx = pos_q + PSW'(1);
            short_ln = beat & chk_en & eol & (idx < expw);
            long_ln  = beat & chk_en & ~eol & (expw != '0) & (idx >= expw);
         end
         always_ff @(posedge clk) begin
            if (!rst_n)     pos_q <= '0;
            else if (beat)  pos_q <= eol ? '0 : idx;
         end
      end else begin : g_nowidth
         always_comb begin
            short_ln = 1'b0;
            long_ln  = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/vsc_sat_cnt.sv
module vsc_sat_cnt #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   output logic [CW-1:0] count
);
   initial assert (CW >= 1) else $error("vsc_sat_cnt: CW must be positive");

   always_ff @(posedge clk) begin
      if (!rst_n)                count <= '0;
      else if (inc && !(&count)) count <= count + CW'(1);
   end
endmodule

// File: rtl/vsc_mon.sv
module vsc_mon
   import vsc_pkg::*;
#(
   parameter int DW        = 24,
   parameter int WW        = 12,
   parameter int CW        = 16,
   parameter bit WIDTH_CHK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DW-1:0]    s_tdata,
   input  logic             s_tvalid,
   input  logic             s_tready,
   input  logic             s_tuser,
   input  logic             s_tlast,
   input  logic [ERR_N-1:0] err_mask,
   input  logic             err_clr,
   input  logic             width_chk_en,
   input  logic [WW-1:0]    exp_width,
   output logic [ERR_N-1:0] err_flags,
   output logic             err_any,
   output logic [CW-1:0]    sof_count,
   output logic [CW-1:0]    eol_count
);
   localparam int PW   = DW + 2;
   localparam int NCNT = 2;

   initial assert (DW >= 1) else $error("vsc_mon: DW must be positive");

   logic     beat;
   err_vec_t hit;
   err_vec_t flags_q;
   logic [NCNT-1:0] cnt_inc;
   logic [CW-1:0]   cnt_val [NCNT];

   vsc_hold_mon #(.PW(PW)) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .valid       (s_tvalid),
      .ready       (s_tready),
      .payload     ({s_tuser, s_tlast, s_tdata}),
      .hold_hit    (hit[ERR_HOLD]),
      .retract_hit (hit[ERR_RETRACT]),
      .beat        (beat)
   );

   vsc_frame_mon #(.WW(WW), .WIDTH_CHK(WIDTH_CHK)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .beat      (beat),
      .sof       (s_tuser),
      .eol       (s_tlast),
      .chk_en    (width_chk_en),
      .exp_width (exp_width),
      .sof_rep   (hit[ERR_SOF_REP]),
      .eol_rep   (hit[ERR_EOL_REP]),
      .prefrm    (hit[ERR_PREFRM]),
      .short_ln  (hit[ERR_SHORT]),
      .long_ln   (hit[ERR_LONG])
   );

   always_ff @(posedge clk) begin
      if (!rst_n || err_clr) flags_q <= '0;
      else                   flags_q <= flags_q | hit;
   end

   assign cnt_inc = {beat & s_tlast, beat & s_tuser};

   generate
      for (genvar g = 0; g < NCNT; g++) begin : g_cnt
         vsc_sat_cnt #(.CW(CW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cnt_inc[g]),
            .count (cnt_val[g])
         );
      end
   endgenerate

   always_comb begin
      err_flags = flags_q;
      err_any   = |(flags_q & ~err_mask);
      sof_count = cnt_val[0];
      eol_count = cnt_val[1];
   end
endmodule

// File: rtl/vsc_mon_chk.sv
module vsc_mon_chk
   import vsc_pkg::*;
#(
   parameter int DW = 24,
   parameter int CW = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DW-1:0]    s_tdata,
   input logic             s_tvalid,
   input logic             s_tready,
   input logic             s_tuser,
   input logic             s_tlast,
   input logic             err_clr,
   input logic [ERR_N-1:0] err_flags,
   input logic [CW-1:0]    sof_count,
   input logic [CW-1:0]    eol_count
);
   AST_HOLD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(s_tvalid && !s_tready) && s_tvalid && !err_clr &&
       {s_tuser, s_tlast, s_tdata} != $past({s_tuser, s_tlast, s_tdata}))
      |=> err_flags[ERR_HOLD]); // R1
   AST_RETRACT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(s_tvalid && !s_tready) && !s_tvalid && !err_clr)
      |=> err_flags[ERR_RETRACT]); // R2
   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !err_clr |=> ((err_flags & $past(err_flags)) == $past(err_flags))); // R8
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      err_clr |=> (err_flags == '0)); // R8
   AST_SOF_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (sof_count == $past(sof_count) ||
                        sof_count == $past(sof_count) + CW'(1))); // R12
   AST_EOL_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (eol_count == $past(eol_count) ||
                        eol_count == $past(eol_count) + CW'(1))); // R12
endmodule

bind vsc_mon vsc_mon_chk #(.DW(DW), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .s_tdata   (s_tdata),
   .s_tvalid  (s_tvalid),
   .s_tready  (s_tready),
   .s_tuser   (s_tuser),
   .s_tlast   (s_tlast),
   .err_clr   (err_clr),
   .err_flags (err_flags),
   .sof_count (sof_count),
   .eol_count (eol_count)
);

// File: tb/tb_vsc_mon.sv
module tb_vsc_mon;
   localparam int DW = 8;
   localparam int WW = 4;
   localparam int CW = 3;
   localparam int NV = 20;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [DW-1:0] s_tdata;
   logic          s_tvalid, s_tready, s_tuser, s_tlast;
   logic [6:0]    err_mask;
   logic          err_clr;
   logic          width_chk_en;
   logic [WW-1:0] exp_width;
   logic [6:0]    err_flags;
   logic          err_any;
   logic [CW-1:0] sof_count, eol_count;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   vsc_mon #(.DW(DW), .WW(WW), .CW(CW), .WIDTH_CHK(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
      .s_tready(s_tready), .s_tuser(s_tuser), .s_tlast(s_tlast),
      .err_mask(err_mask), .err_clr(err_clr), .width_chk_en(width_chk_en),
      .exp_width(exp_width), .err_flags(err_flags), .err_any(err_any),
      .sof_count(sof_count), .eol_count(eol_count)
   );

   // {valid, ready, user, last, data[7:0], clr, expected flags[6:0]}
   localparam logic [19:0] TBL [NV] = '{
      {4'b0010, 8'h00, 1'b0, 7'h00}, // R5 early user, no transfer
      {4'b1010, 8'h11, 1'b0, 7'h00}, // R3 pending
      {4'b1110, 8'h11, 1'b0, 7'h00}, // R3 frame start beat
      {4'b1100, 8'h12, 1'b0, 7'h00}, // R3 back to back
      {4'b1001, 8'h13, 1'b0, 7'h00},
      {4'b1001, 8'h13, 1'b0, 7'h00},
      {4'b1101, 8'h13, 1'b0, 7'h00}, // R3 line end
      {4'b0100, 8'h00, 1'b0, 7'h00}, // R3 ready without valid
      {4'b1000, 8'h20, 1'b0, 7'h00},
      {4'b1000, 8'h21, 1'b0, 7'h01}, // R1 data changed
      {4'b0000, 8'h21, 1'b0, 7'h03}, // R2 valid dropped
      {4'b0000, 8'h00, 1'b1, 7'h00}, // R8 clear
      {4'b1110, 8'h30, 1'b0, 7'h00},
      {4'b1110, 8'h31, 1'b0, 7'h04}, // R4 repeated start
      {4'b1101, 8'h32, 1'b0, 7'h04}, // R8 sticky
      {4'b1101, 8'h33, 1'b0, 7'h0C}, // R6 repeated end
      {4'b0000, 8'h00, 1'b1, 7'h00},
      {4'b1000, 8'h40, 1'b0, 7'h00},
      {4'b1000, 8'h41, 1'b1, 7'h00}, // R8 clear beats violation
      {4'b1100, 8'h41, 1'b0, 7'h00}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic r, input logic u, input logic l,
                       input logic [DW-1:0] d, input logic c);
      s_tvalid = v; s_tready = r; s_tuser = u; s_tlast = l; s_tdata = d; err_clr = c;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      step(1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
   end

   initial begin
      err_mask = '0; width_chk_en = 1'b0; exp_width = '0;
      s_tvalid = 1'b0; s_tready = 1'b0; s_tuser = 1'b0; s_tlast = 1'b0;
      s_tdata = '0; err_clr = 1'b0;
      @(negedge clk);
      do_reset();
      check("R13 flags", 32'(err_flags), 0);
      check("R13 any", 32'(err_any), 0);
      check("R13 sof_count", 32'(sof_count), 0);
      check("R13 eol_count", 32'(eol_count), 0);

      for (int i = 0; i < NV; i++) begin
         step(TBL[i][19], TBL[i][18], TBL[i][17], TBL[i][16], TBL[i][15:8], TBL[i][7]);
         check($sformatf("table step %0d", i), 32'(err_flags), 32'(TBL[i][6:0]));
      end
      step(1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
      check("R12 sof_count", 32'(sof_count), 3);
      check("R12 eol_count", 32'(eol_count), 3);

      // R7 data before first frame start, then R9 masking
      do_reset();
      step(1'b1, 1'b1, 1'b0, 1'b0, 8'h01, 1'b0);
      check("R7 prefrm", 32'(err_flags), 32'h10);
      check("R9 any unmasked", 32'(err_any), 1);
      err_mask = 7'h10;
      #1;
      check("R9 any masked", 32'(err_any), 0);
      err_mask = 7'h6F;
      #1;
      check("R9 other mask", 32'(err_any), 1);
      err_mask = 7'h7F;
      step(1'b1, 1'b1, 1'b1, 1'b0, 8'h02, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b1);
      step(1'b1, 1'b1, 1'b0, 1'b0, 8'h03, 1'b0);
      check("R7 after start", 32'(err_flags), 0);
      err_mask = '0;

      // R10 / R11 line width checks, width 3
      do_reset();
      width_chk_en = 1'b1; exp_width = 4'd3;
      step(1'b1, 1'b1, 1'b1, 1'b0, 8'h10, 1'b0);
      step(1'b1, 1'b1, 1'b0, 1'b0, 8'h11, 1'b0);
      step(1'b1, 1'b1, 1'b0, 1'b1, 8'h12, 1'b0);
      check("R10 exact line", 32'(err_flags), 0);
      step(1'b1, 1'b1, 1'b1, 1'b0, 8'h20, 1'b0);
      step(1'b1, 1'b1, 1'b0, 1'b1, 8'h21, 1'b0);
      check("R10 short line", 32'(err_flags), 32'h20);
      step(1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b1);
      step(1'b1, 1'b1, 1'b0, 1'b0, 8'h30, 1'b0);
      step(1'b1, 1'b1, 1'b0, 1'b0, 8'h31, 1'b0);
      check("R11 before limit", 32'(err_flags), 0);
      step(1'b1, 1'b1, 1'b0, 1'b0, 8'h32, 1'b0);
      check("R11 long line", 32'(err_flags), 32'h40);
      width_chk_en = 1'b0;

      // R12 saturation
      do_reset();
      for (int k = 0; k < 9; k++) step(1'b1, 1'b1, 1'b1, 1'b1, 8'(k), 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
      check("R12 sof saturate", 32'(sof_count), 7);
      check("R12 eol saturate", 32'(eol_count), 7);

      finish_run();
   end
endmodule